// File: doc/BRIEF.md
# Current-loop fault supervisor

This block sits between the register file of a 4-20 mA loop transmitter and its sigma-delta modulator. Each cycle it decides which 16-bit code the modulator receives: the requested code, the low alarm code or the high alarm code. It watches three kinds of fault. A host that stops issuing valid writes trips an inactivity timer. The analog loop driver may report that it cannot hold the requested current. The serial front end may report a badly framed write. The block reflects these faults in a status byte with sticky bits and in an active-low error flag.

Both timers count a slow tick. A prescaler produces one tick every `TICK_DIV` system clocks, nominally 50 ms. During a loop fault the block drops to the low alarm code. After a programmable number of ticks it gives the requested code one more cycle to see whether the loop has recovered. If software prefers, that retry happens only when the status byte is read. The two alarm bytes are held inside the block, and writes that fall outside their permitted range are refused.

Top module: `loop_fault_supervisor`

## Requirements
- R1: After reset, `dac_code` equals `req_code`, `status` equals 8'hE0 with bit 4 set to `err_lvl_pin`, and `err_n` is 1.
- R2: Let T be `cfg[3:1]`. If `wr_valid` is absent for T+1 ticks, a timeout is raised and shown on `status[2]`, and `err_n` goes to 0. The next `wr_valid` clears the timeout and restarts the count. One tick occurs every `TICK_DIV` clocks, counted from reset.
- R3: While a timeout is raised and `cfg[4]` is 0, `dac_code` is {high alarm byte, 8'h00} if `err_lvl_pin` is 1, or {low alarm byte, 8'h00} if it is 0. With `cfg[4]` at 1, `dac_code` stays at `req_code` while `err_n` still goes to 0.
- R4: With `cfg[0]` at 1, the timeout has no effect: `status[2]` is 0, `err_n` is not pulled low by it, and `dac_code` is `req_code`.
- R5: With `cfg[6]` at 0 and no loop error live, a high `loop_fault` sets the live loop error (`status[0]`) and the sticky loop bit (`status[1]`) in the next cycle. While the live loop error is set, `dac_code` is {low alarm byte, 8'h00}.
- R6: With `cfg[6]` and `cfg[7]` at 0, a live loop error clears after `cfg[10:8]`+1 ticks. `dac_code` then returns to `req_code`. If `loop_fault` is still high in that cycle, the live error sets again in the next cycle.
- R7: With `cfg[7]` at 1 and `cfg[6]` at 0, a live loop error is held until a `status_rd` pulse, and clears in the cycle after that pulse.
- R8: With `cfg[6]` at 1, `dac_code` is never replaced because of a loop fault, and `status[0]` equals `loop_fault` delayed by one cycle.
- R9: A live loop error with `cfg[6]` at 0 takes priority over a timeout, so `dac_code` is {low alarm byte, 8'h00} whatever the level of `err_lvl_pin`.
- R10: `status[3]` is set the cycle after a `frame_err` pulse. The sticky bits `status[3]` and `status[1]` clear in the cycle after `status_rd`. A new set in the same cycle as the read wins, and `status[1]` stays set while a loop error is live. `status[7:5]` always reads 3'b111.
- R11: `err_n` is 0 while `status[3]` is set, and while a loop error is live unless `cfg[5]` is 1. A frame error never changes `dac_code`.
- R12: The low alarm byte resets to 8'h24 and accepts a write only when `alarm_wdata` is at most 8'h80. The high alarm byte resets to 8'hE8 and accepts a write only when `alarm_wdata` is at least 8'h80. A refused write leaves the old value in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Pulse for a valid register write, no-op included |
| frame_err | input | 1 | Pulse for a write with a bad clock count |
| loop_fault | input | 1 | Loop driver cannot hold the current (level) |
| err_lvl_pin | input | 1 | Selects the alarm band used on a timeout |
| status_rd | input | 1 | Pulse when the status byte is read |
| cfg | input | 16 | Error configuration word |
| req_code | input | CODE_W | Requested output code |
| alarm_wdata | input | 8 | Data for an alarm byte write |
| alarm_lo_we | input | 1 | Write the low alarm byte |
| alarm_hi_we | input | 1 | Write the high alarm byte |
| dac_code | output | CODE_W | Code sent to the modulator |
| status | output | 8 | Status byte |
| err_n | output | 1 | Active-low error flag |

## Verification
Some properties are checked on every cycle. A live loop error forces the low alarm code, and a timeout selects the alarm band from the pin. A frame-error sticky bit holds the flag low. The alarm bytes stay within their ranges. A masked loop fault is mirrored one cycle late, and a read-only retry holds the live error until a read arrives. Other behaviour needs the bench's scenarios to become visible. These include the exact tick counts before a timeout or a retry, and the requested code returning when the loop recovers. They also include refused alarm writes, and sticky bits that survive until a read and then clear.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   localparam int ALARM_W     = 8;
   localparam int FIELD_W     = 3;
   // configuration word bit positions
   localparam int B_SPI_OFF   = 0;
   localparam int F_SPI_LO    = 1;
   localparam int B_SPI_KEEP  = 4;
   localparam int B_LOOP_NOFL = 5;
   localparam int B_LOOP_KEEP = 6;
   localparam int B_RETRY_RD  = 7;
   localparam int F_RETRY_LO  = 8;

   typedef struct packed {
      logic [2:0] res;
      logic       pin;
      logic       ferr;
      logic       spi_to;
      logic       loop_seen;
      logic       loop_live;
   } status_t;
endpackage

// File: rtl/lfs_tick.sv
module lfs_tick #(
   parameter int DIV = 6_250_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   if (DIV < 2) begin : g_bad_div
      $error("lfs_tick: DIV must be at least 2");
   end

   assign tick = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lfs_interval_timer.sv
module lfs_interval_timer #(
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          run,
   input  logic          tick,
   input  logic [FW-1:0] limit,
   output logic          expire
);
   logic [FW-1:0] cnt;

   assign expire = run & tick & (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt <= '0;
      else if (restart || !run || expire)  cnt <= '0;
      else if (tick)                       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lfs_alarm_byte.sv
module lfs_alarm_byte #(
   parameter int          W       = 8,
   parameter logic [W-1:0] DEFAULT = '0,
   parameter bit          UPPER   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MID = W'(1) << (W - 1);

   logic accept;

   if (UPPER) begin : g_upper
      assign accept = (wdata >= MID);
   end else begin : g_lower
      assign accept = (wdata <= MID);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            q <= DEFAULT;
      else if (we && accept) q <= wdata;
   end
endmodule

// File: rtl/loop_fault_supervisor.sv
module loop_fault_supervisor
   import lfs_pkg::*;
#(
   parameter int CODE_W   = 16,
   parameter int TICK_DIV = 6_250_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              frame_err,
   input  logic              loop_fault,
   input  logic              err_lvl_pin,
   input  logic              status_rd,
   input  logic [15:0]       cfg,
   input  logic [CODE_W-1:0] req_code,
   input  logic [7:0]        alarm_wdata,
   input  logic              alarm_lo_we,
   input  logic              alarm_hi_we,
   output logic [CODE_W-1:0] dac_code,
   output logic [7:0]        status,
   output logic              err_n
);
   localparam int PAD_W = CODE_W - ALARM_W;

   if (CODE_W <= ALARM_W) begin : g_bad_width
      $error("loop_fault_supervisor: CODE_W must exceed the alarm byte width");
   end

   logic tick, spi_exp, retry_exp;
   logic spi_to_q, live_q, live_n, seen_q, ferr_q;
   logic spi_to_eff, retry_run;
   logic [ALARM_W-1:0] alarm_q [2];
   logic [ALARM_W-1:0] alarm_lo_q, alarm_hi_q;
   logic [1:0] alarm_we;
   status_t st;

   lfs_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   lfs_interval_timer #(.FW(FIELD_W)) u_spi_tmr (
      .clk(clk), .rst_n(rst_n), .restart(wr_valid), .run(~spi_to_q),
      .tick(tick), .limit(cfg[F_SPI_LO +: FIELD_W]), .expire(spi_exp));

   assign retry_run = live_q & ~cfg[B_LOOP_KEEP] & ~cfg[B_RETRY_RD];

   lfs_interval_timer #(.FW(FIELD_W)) u_retry_tmr (
      .clk(clk), .rst_n(rst_n), .restart(1'b0), .run(retry_run),
      .tick(tick), .limit(cfg[F_RETRY_LO +: FIELD_W]), .expire(retry_exp));

   assign alarm_we = {alarm_hi_we, alarm_lo_we};

   for (genvar g = 0; g < 2; g++) begin : g_alarm
      lfs_alarm_byte #(
         .W(ALARM_W),
         .DEFAULT((g == 0) ? 8'h24 : 8'hE8),
         .UPPER(g == 1)
      ) u_byte (
         .clk(clk), .rst_n(rst_n), .we(alarm_we[g]),
         .wdata(alarm_wdata), .q(alarm_q[g]));
   end

   assign alarm_lo_q = alarm_q[0];
   assign alarm_hi_q = alarm_q[1];

   // next live loop state: mirrored when masked, retried otherwise
   always_comb begin
      if (cfg[B_LOOP_KEEP])     live_n = loop_fault;
      else if (!live_q)         live_n = loop_fault;
      else if (cfg[B_RETRY_RD]) live_n = ~status_rd;
      else                      live_n = ~retry_exp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spi_to_q <= 1'b0;
         live_q   <= 1'b0;
         seen_q   <= 1'b0;
         ferr_q   <= 1'b0;
      end else begin
         if (wr_valid)     spi_to_q <= 1'b0;
         else if (spi_exp) spi_to_q <= 1'b1;
         live_q <= live_n;
         seen_q <= (seen_q & ~status_rd) | live_n;
         ferr_q <= (ferr_q & ~status_rd) | frame_err;
      end
   end

   assign spi_to_eff = spi_to_q & ~cfg[B_SPI_OFF];

   always_comb begin
      if (live_q && !cfg[B_LOOP_KEEP])
         dac_code = {alarm_lo_q, {PAD_W{1'b0}}};
      else if (spi_to_eff && !cfg[B_SPI_KEEP])
         dac_code = {err_lvl_pin ? alarm_hi_q : alarm_lo_q, {PAD_W{1'b0}}};
      else
         dac_code = req_code;
   end

   assign st.res       = 3'b111;
   assign st.pin       = err_lvl_pin;
   assign st.ferr      = ferr_q;
   assign st.spi_to    = spi_to_eff;
   assign st.loop_seen = seen_q;
   assign st.loop_live = live_q;
   assign status       = st;

   assign err_n = ~(spi_to_eff | ferr_q | (live_q & ~cfg[B_LOOP_NOFL]));
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
   parameter int CODE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              frame_err,
   input logic              loop_fault,
   input logic              status_rd,
   input logic [15:0]       cfg,
   input logic [CODE_W-1:0] dac_code,
   input logic [7:0]        status,
   input logic              err_n,
   input logic [7:0]        alarm_lo,
   input logic [7:0]        alarm_hi
);
   localparam int PAD_W = CODE_W - 8;

   assert_spi_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !status[2]);

   assert_spi_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status[2] && !cfg[4] && !(status[0] && !cfg[6])) |->
      dac_code == {(status[4] ? alarm_hi : alarm_lo), {PAD_W{1'b0}}});

   assert_spi_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[0] |-> !status[2]);

   assert_hold_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[7] && !cfg[6] && status[0] && !status_rd) |=> status[0]);

   assert_masked_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[6] |=> (status[0] == $past(loop_fault)));

   assert_loop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && !cfg[6]) |-> dac_code == {alarm_lo, {PAD_W{1'b0}}});

   assert_frame_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> status[3]);

   assert_frame_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !frame_err) |=> !status[3]);

   assert_frame_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] |-> !err_n);

   assert_alarm_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_lo <= 8'h80) && (alarm_hi >= 8'h80));
endmodule

bind loop_fault_supervisor lfs_checker #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .frame_err(frame_err),
   .loop_fault(loop_fault), .status_rd(status_rd), .cfg(cfg),
   .dac_code(dac_code), .status(status), .err_n(err_n),
   .alarm_lo(alarm_lo_q), .alarm_hi(alarm_hi_q));

// File: tb/sim_loop_fault_supervisor.sv
`timescale 1ns/1ps
module sim_loop_fault_supervisor;
   localparam int DIV = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 0, frame_err = 0, loop_fault = 0, err_lvl_pin = 0, status_rd = 0;
   logic [15:0] cfg = 16'h0102;
   logic [15:0] req_code = 16'h1234;
   logic [7:0]  alarm_wdata = 0;
   logic alarm_lo_we = 0, alarm_hi_we = 0;
   logic [15:0] dac_code;
   logic [7:0]  status;
   logic        err_n;

   always #4 clk = ~clk;

   loop_fault_supervisor #(.CODE_W(16), .TICK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .frame_err(frame_err),
      .loop_fault(loop_fault), .err_lvl_pin(err_lvl_pin), .status_rd(status_rd),
      .cfg(cfg), .req_code(req_code), .alarm_wdata(alarm_wdata),
      .alarm_lo_we(alarm_lo_we), .alarm_hi_we(alarm_hi_we),
      .dac_code(dac_code), .status(status), .err_n(err_n));

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_pc, m_st, m_rt, m_to, m_live, m_seen, m_ferr;
   int m_lo, m_hi;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_st = 0; m_rt = 0; m_to = 0; m_live = 0; m_seen = 0; m_ferr = 0;
         m_lo = 8'h24; m_hi = 8'hE8;
      end else begin
         int tk, spi_lim, rt_lim;
         tk = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         spi_lim = int'(cfg[3:1]) + 1;
         rt_lim  = int'(cfg[10:8]) + 1;
         if (wr_valid) begin m_st = 0; m_to = 0; end
         else if (m_to == 0 && tk) begin
            m_st++;
            if (m_st == spi_lim) begin m_to = 1; m_st = 0; end
         end
         if (cfg[6]) begin m_live = loop_fault; m_rt = 0; end
         else if (m_live == 0) begin m_live = loop_fault; m_rt = 0; end
         else if (cfg[7]) begin if (status_rd) m_live = 0; m_rt = 0; end
         else if (tk) begin
            m_rt++;
            if (m_rt == rt_lim) begin m_live = 0; m_rt = 0; end
         end
         m_seen = ((m_seen != 0) && !status_rd) || (m_live != 0);
         m_ferr = ((m_ferr != 0) && !status_rd) || frame_err;
         if (alarm_lo_we && alarm_wdata <= 8'h80) m_lo = alarm_wdata;
         if (alarm_hi_we && alarm_wdata >= 8'h80) m_hi = alarm_wdata;
      end
   end

   function automatic logic [15:0] exp_code();
      int se;
      se = m_to && !cfg[0];
      if (m_live && !cfg[6]) return {m_lo[7:0], 8'h00};
      if (se && !cfg[4]) return {(err_lvl_pin ? m_hi[7:0] : m_lo[7:0]), 8'h00};
      return req_code;
   endfunction

   function automatic logic [7:0] exp_status();
      int se;
      se = m_to && !cfg[0];
      return {3'b111, err_lvl_pin, m_ferr[0], se[0], m_seen[0], m_live[0]};
   endfunction

   function automatic logic exp_errn();
      int se;
      se = m_to && !cfg[0];
      return !(se || m_ferr || (m_live && !cfg[5]));
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "dac_code model", 32'(dac_code), 32'(exp_code()));
         chk(cur_req, "status model", 32'(status), 32'(exp_status()));
         chk(cur_req, "err_n model", 32'(err_n), 32'(exp_errn()));
      end
   end

   task automatic summary();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic pulse_wr();    wr_valid = 1;   step(1); wr_valid = 0;   endtask
   task automatic pulse_rd();    status_rd = 1;  step(1); status_rd = 0;  endtask
   task automatic pulse_frame(); frame_err = 1;  step(1); frame_err = 0;  endtask
   task automatic wr_lo(input logic [7:0] d); alarm_wdata = d; alarm_lo_we = 1; step(1); alarm_lo_we = 0; endtask
   task automatic wr_hi(input logic [7:0] d); alarm_wdata = d; alarm_hi_we = 1; step(1); alarm_hi_we = 0; endtask

   initial begin
      int reasserts;
      step(3);
      rst_n = 1;
      step(0);
      @(negedge clk);
      cur_req = "R1";
      chk("R1", "reset dac_code", 32'(dac_code), 32'h1234);
      chk("R1", "reset status", 32'(status), 32'hE0);
      chk("R1", "reset err_n", 32'(err_n), 1);
      step(1);

      // R2: regular writes keep the timer from expiring
      cur_req = "R2";
      for (int i = 0; i < 8; i++) begin pulse_wr(); step(7); end
      @(negedge clk);
      chk("R2", "no timeout with writes", 32'(status[2]), 0);
      chk("R2", "code kept with writes", 32'(dac_code), 32'h1234);
      step(25);
      @(negedge clk);
      cur_req = "R3";
      chk("R2", "timeout raised", 32'(status[2]), 1);
      chk("R2", "timeout flag", 32'(err_n), 0);
      chk("R3", "low band on timeout", 32'(dac_code), 32'h2400);
      err_lvl_pin = 1; step(1);
      @(negedge clk);
      chk("R3", "high band on timeout", 32'(dac_code), 32'hE800);
      pulse_wr();
      @(negedge clk);
      chk("R2", "write clears timeout", 32'(status[2]), 0);
      chk("R2", "code back after write", 32'(dac_code), 32'h1234);

      // R3 keep-current option, R4 full mask
      cfg = 16'h0112; step(25);
      @(negedge clk);
      chk("R3", "keep bit timeout flag", 32'(err_n), 0);
      chk("R3", "keep bit code", 32'(dac_code), 32'h1234);
      cur_req = "R4";
      cfg = 16'h0103; step(25);
      @(negedge clk);
      chk("R4", "masked timeout status", 32'(status[2]), 0);
      chk("R4", "masked timeout err_n", 32'(err_n), 1);
      chk("R4", "masked timeout code", 32'(dac_code), 32'h1234);

      // R10 / R11: frame error (timeout still masked)
      cur_req = "R10";
      req_code = 16'hA5C3; step(1);
      pulse_frame();
      @(negedge clk);
      chk("R10", "frame sticky set", 32'(status[3]), 1);
      chk("R11", "frame flag low", 32'(err_n), 0);
      chk("R11", "frame keeps code", 32'(dac_code), 32'hA5C3);
      step(5);
      @(negedge clk);
      chk("R10", "frame sticky held", 32'(status[3]), 1);
      pulse_rd();
      @(negedge clk);
      chk("R10", "frame sticky cleared", 32'(status[3]), 0);
      chk("R11", "flag released", 32'(err_n), 1);

      // R5 / R6: loop fault with periodic retry
      cur_req = "R5";
      err_lvl_pin = 0;
      loop_fault = 1; step(2);
      @(negedge clk);
      chk("R5", "loop alarm code", 32'(dac_code), 32'h2400);
      chk("R5", "loop status bits", 32'(status[1:0]), 3);
      chk("R11", "loop flag", 32'(err_n), 0);
      cur_req = "R6";
      reasserts = 0;
      for (int i = 0; i < 45; i++) begin
         @(negedge clk);
         if (dac_code == 16'hA5C3) reasserts++;
      end
      chk("R6", "retry seen during fault", 32'(reasserts > 0), 1);
      step(1);
      loop_fault = 0; step(25);
      @(negedge clk);
      chk("R6", "live cleared after retry", 32'(status[0]), 0);
      chk("R6", "requested code restored", 32'(dac_code), 32'hA5C3);
      chk("R10", "loop sticky remains", 32'(status[1]), 1);
      pulse_rd();
      @(negedge clk);
      chk("R10", "loop sticky cleared", 32'(status[1]), 0);

      // R7: retry only on status read
      cur_req = "R7";
      cfg = 16'h0183;
      loop_fault = 1; step(2); loop_fault = 0; step(40);
      @(negedge clk);
      chk("R7", "held without read", 32'(status[0]), 1);
      chk("R7", "alarm held", 32'(dac_code), 32'h2400);
      pulse_rd();
      @(negedge clk);
      chk("R7", "cleared by read", 32'(status[0]), 0);
      chk("R7", "code after read", 32'(dac_code), 32'hA5C3);

      // R8: masked loop fault
      cur_req = "R8";
      cfg = 16'h0143;
      loop_fault = 1; step(2);
      @(negedge clk);
      chk("R8", "masked keeps code", 32'(dac_code), 32'hA5C3);
      chk("R8", "masked live bit", 32'(status[0]), 1);
      chk("R11", "masked loop flag", 32'(err_n), 0);
      cfg = 16'h0163; step(1);
      @(negedge clk);
      chk("R11", "loop flag disabled", 32'(err_n), 1);
      loop_fault = 0; step(2);
      @(negedge clk);
      chk("R8", "masked live follows", 32'(status[0]), 0);
      pulse_rd();

      // R9: loop fault beats timeout with pin high
      cur_req = "R9";
      cfg = 16'h0102; err_lvl_pin = 1; step(25);
      @(negedge clk);
      chk("R9", "timeout high band first", 32'(dac_code), 32'hE800);
      loop_fault = 1; step(2);
      @(negedge clk);
      chk("R9", "loop wins over timeout", 32'(dac_code), 32'h2400);
      loop_fault = 0; step(30);
      pulse_wr(); pulse_rd();

      // R12: alarm byte ranges (timeout held by letting it expire)
      cur_req = "R12";
      wr_lo(8'h90); wr_hi(8'h7F);
      err_lvl_pin = 0; step(25);
      @(negedge clk);
      chk("R12", "low refused", 32'(dac_code), 32'h2400);
      err_lvl_pin = 1; step(1);
      @(negedge clk);
      chk("R12", "high refused", 32'(dac_code), 32'hE800);
      wr_hi(8'h80);
      @(negedge clk);
      chk("R12", "high at midpoint", 32'(dac_code), 32'h8000);
      err_lvl_pin = 0; wr_lo(8'h80);
      @(negedge clk);
      chk("R12", "low at midpoint", 32'(dac_code), 32'h8000);
      wr_lo(8'h00);
      @(negedge clk);
      chk("R12", "low zero", 32'(dac_code), 32'h0000);

      // R2: longer timeout field (4 ticks)
      cur_req = "R2";
      cfg = 16'h0106; pulse_wr();
      step(28);
      @(negedge clk);
      chk("R2", "not yet timed out", 32'(status[2]), 0);
      step(17);
      @(negedge clk);
      chk("R2", "timed out after field", 32'(status[2]), 1);
      step(2);
      summary();
   end
endmodule